// File: doc/BRIEF.md
# Clock Multiplier Control Register Bank

This block holds the control and status registers for a small bank of clock multipliers. Software stages an integer multiplier and spread-spectrum settings in each multiplier's first control word. The staged multiplier reaches the clock generator only when software writes that word with its commit bit set. The commit bit is also the busy flag. It stays set while a per-multiplier lock timer runs and clears itself when the timer expires. In the same cycle the multiplier's lock flag returns to 1. The lock flags of all multipliers are gathered in one read-only status word at fixed, non-contiguous bit positions.

The block does not model the analog loop. It exports the committed effective multiplier (field plus one). The synthesized clock is reference × effective multiplier × 2. A second control word per multiplier holds a fractional setting. Writing it with all zeros turns off fractional multiplication and dithering.

The bus is a plain word-addressed port with single-cycle write strobes and registered read data. Word 0 is the status word and word 1 is unmapped. Multiplier k (k counted from 0) has its first control word at word 2+2k and its second control word at word 3+2k.

Top module: `pllc_bank`

## Requirements
- R1: After reset every first control word reads as the default multiplier field in bits 27:20 with all other bits 0. Every second control word reads 0, every lock flag is 1, and each `eff_mult_o` slice equals the default field plus one.
- R2: A write to a first control word with bit 31 clear, made while that multiplier is not busy, stores these fields for readback: bits 27:20 (multiplier), 18:16 (mode: 18 fractional, 17 dithering, 16 center spread), 14:8 (modulation rate) and 6:0 (modulation depth). Bits 30:28, 19, 15 and 7 read 0. `eff_mult_o` does not change.
- R3: A write to a first control word with bit 31 set, made while that multiplier is not busy, stores the fields as in R2. On the same clock edge it loads that multiplier's `eff_mult_o` slice with bits 27:20 plus one, giving a range of 1 to 256. Bit 31 then reads 1.
- R4: From the edge that accepts a commit, the multiplier's lock flag stays 0 for exactly LOCK_CYCLES cycles. It returns to 1 on the same edge on which bit 31 of its first control word returns to 0.
- R5: While bit 31 of a multiplier's first control word reads 1, writes to either of that multiplier's control words are ignored. The readback and `eff_mult_o` keep their values.
- R6: Status word 0 holds the lock flag of multiplier n (n = 1..NUM_PLL) at bit 8+n-1 for n<3, at bit 11 for n=3 and at bit 9+n for n>3. All other bits read 0, and writes to word 0 have no effect.
- R7: A commit on one multiplier changes neither the `eff_mult_o` slice, the lock flag nor the busy bit of any other multiplier.
- R8: Writing all zeros to a second control word, while not busy, clears bits 18 and 17 of the same multiplier's first control word and leaves bit 16 and every other field alone. A nonzero write stores its low FRAC_W bits for readback and leaves the mode bits unchanged.
- R9: `rdata` updates on the edge that samples `rd_en` and holds its value while `rd_en` is low. Reads of unmapped words return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| eff_mult_o | output | NUM_PLL*9 | Committed effective multiplier per multiplier, 9 bits each |
| lock_o | output | NUM_PLL | Lock flag per multiplier |

## Verification
Some properties are checked on every cycle by the embedded assertions. A lock flag and a busy bit are never both set. The exported multiplier moves only on the edge where a commit is accepted, and never while busy. A rising lock flag coincides with the busy bit falling. The lock counter stays in range, and unmapped reads return zero. Other behaviour only shows up in the bench's scenarios: the exact length of the lock window, field masking on readback, status bit placement, zero-write clearing of the mode bits, and isolation between multipliers. The bench checks these through directed cases and a seeded random mix of writes and reads against a cycle-counted reference model.

// File: rtl/pllc_pkg.sv
package pllc_pkg;

  localparam int KICK_BIT = 31;
  localparam int MULT_LSB = 20;
  localparam int MULT_W   = 8;
  localparam int MODE_LSB = 16;
  localparam int MODE_W   = 3;
  localparam int RATE_LSB = 8;
  localparam int RATE_W   = 7;
  localparam int DEPT_LSB = 0;
  localparam int DEPT_W   = 7;
  localparam int EFF_W    = MULT_W + 1;

  // mode flag positions inside the 3-bit mode field
  localparam int MODE_FRAC = 2;
  localparam int MODE_DITH = 1;
  localparam int MODE_CENT = 0;

  typedef struct packed {
    logic [MULT_W-1:0] mult;
    logic [MODE_W-1:0] mode;
    logic [RATE_W-1:0] rate;
    logic [DEPT_W-1:0] dept;
  } stage_t;

  function automatic logic [31:0] pack_word(input logic kick, input stage_t s);
    logic [31:0] w;
    w = '0;
    w[KICK_BIT] = kick;
    w[MULT_LSB +: MULT_W] = s.mult;
    w[MODE_LSB +: MODE_W] = s.mode;
    w[RATE_LSB +: RATE_W] = s.rate;
    w[DEPT_LSB +: DEPT_W] = s.dept;
    return w;
  endfunction

  function automatic stage_t unpack_word(input logic [31:0] w);
    stage_t s;
    s.mult = w[MULT_LSB +: MULT_W];
    s.mode = w[MODE_LSB +: MODE_W];
    s.rate = w[RATE_LSB +: RATE_W];
    s.dept = w[DEPT_LSB +: DEPT_W];
    return s;
  endfunction

  // status bit of multiplier n, counted from 1; bit 10 and bit 12 are skipped
  function automatic int lock_pos(input int n);
    if (n < 3)       return 8 + n - 1;
    else if (n == 3) return 11;
    else             return 9 + n;
  endfunction

endpackage

// File: rtl/pllc_lock_timer.sv
module pllc_lock_timer #(
  parameter int LOCK_CYCLES = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CNT_W'(LOCK_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == CNT_W'(1));

  p_cnt_range_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(LOCK_CYCLES));

  p_done_after_run_r4: assert property (@(posedge clk) disable iff (rst)
    start |=> !done || (LOCK_CYCLES == 1));

endmodule

// File: rtl/pllc_chan.sv
module pllc_chan
  import pllc_pkg::*;
#(
  parameter int              LOCK_CYCLES = 6,
  parameter logic [MULT_W-1:0] DEF_MULT  = 8'd49,
  parameter int              FRAC_W      = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctl,
  input  logic             wr_frac,
  input  logic [31:0]      wdata,
  output logic [31:0]      ctl_word,
  output logic [31:0]      frac_word,
  output logic [EFF_W-1:0] eff_mult,
  output logic             locked
);
  stage_t             stage_q;
  logic               kick_q;
  logic               lock_q;
  logic [FRAC_W-1:0]  frac_q;
  logic [EFF_W-1:0]   eff_q;
  logic               t_done;
  logic               ctl_ok;
  logic               frac_ok;
  logic               kick_go;
  stage_t             wr_stage;
  logic               unused_wbits;

  assign wr_stage     = unpack_word(wdata);
  assign ctl_ok       = wr_ctl && !kick_q;
  assign frac_ok      = wr_frac && !kick_q;
  assign kick_go      = ctl_ok && wdata[KICK_BIT];
  assign unused_wbits = ^{wdata[30:28], wdata[19], wdata[15], wdata[7]};

  pllc_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (kick_go),
    .done  (t_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q      <= '0;
      stage_q.mult <= DEF_MULT;
      kick_q       <= 1'b0;
      lock_q       <= 1'b1;
      frac_q       <= '0;
      eff_q        <= EFF_W'(DEF_MULT) + 1'b1;
    end else begin
      if (ctl_ok) begin
        stage_q <= wr_stage;
      end else if (frac_ok && (wdata == 32'd0)) begin
        stage_q.mode[MODE_FRAC] <= 1'b0;
        stage_q.mode[MODE_DITH] <= 1'b0;
      end
      if (frac_ok) begin
        frac_q <= wdata[FRAC_W-1:0];
      end
      if (kick_go) begin
        kick_q <= 1'b1;
        lock_q <= 1'b0;
        eff_q  <= EFF_W'(wr_stage.mult) + 1'b1;
      end else if (t_done) begin
        kick_q <= 1'b0;
        lock_q <= 1'b1;
      end
    end
  end

  assign ctl_word  = pack_word(kick_q, stage_q);
  assign frac_word = {{(32 - FRAC_W){1'b0}}, frac_q};
  assign eff_mult  = eff_q;
  assign locked    = lock_q;

  p_lock_busy_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(lock_q && kick_q));

  p_lock_with_clear_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_q) |-> $fell(kick_q));

  p_busy_holds_mult_r5: assert property (@(posedge clk) disable iff (rst)
    kick_q |=> $stable(eff_q));

  p_busy_holds_stage_r5: assert property (@(posedge clk) disable iff (rst)
    kick_q |=> $stable(stage_q) && $stable(frac_q));

  p_mult_moves_on_commit_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(eff_q) |-> $rose(kick_q));

  p_eff_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    eff_q != '0);

endmodule

// File: rtl/pllc_rdmux.sv
module pllc_rdmux
  import pllc_pkg::*;
#(
  parameter int NUM_PLL = 4,
  parameter int ADDR_W  = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_PLL*32-1:0] ctl_flat,
  input  logic [NUM_PLL*32-1:0] frac_flat,
  input  logic [NUM_PLL-1:0]   lock_vec,
  output logic [31:0]          rdata
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = '0;

  logic [31:0] nxt;
  logic        hit;
  logic [31:0] rdata_q;

  always_comb begin
    nxt = '0;
    hit = 1'b0;
    if (addr == STAT_ADDR) begin
      hit = 1'b1;
      for (int k = 0; k < NUM_PLL; k++) begin
        nxt[lock_pos(k + 1)] = lock_vec[k];
      end
    end
    for (int k = 0; k < NUM_PLL; k++) begin
      if (addr == ADDR_W'(2 + 2 * k)) begin
        hit = 1'b1;
        nxt = ctl_flat[k*32 +: 32];
      end
      if (addr == ADDR_W'(3 + 2 * k)) begin
        hit = 1'b1;
        nxt = frac_flat[k*32 +: 32];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= nxt;
    end
  end

  assign rdata = rdata_q;

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !hit) |=> (rdata == 32'd0));

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

endmodule

// File: rtl/pllc_bank.sv
module pllc_bank
  import pllc_pkg::*;
#(
  parameter int                NUM_PLL     = 4,
  parameter int                ADDR_W      = 5,
  parameter int                LOCK_CYCLES = 6,
  parameter logic [MULT_W-1:0] DEF_MULT    = 8'd49,
  parameter int                FRAC_W      = 24
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [31:0]                wdata,
  output logic [31:0]                rdata,
  output logic [NUM_PLL*EFF_W-1:0]   eff_mult_o,
  output logic [NUM_PLL-1:0]         lock_o
);
  logic [NUM_PLL*32-1:0] ctl_flat;
  logic [NUM_PLL*32-1:0] frac_flat;
  logic [NUM_PLL-1:0]    lock_vec;

  for (genvar k = 0; k < NUM_PLL; k++) begin : g_chan
    logic wr_ctl;
    logic wr_frac;
    assign wr_ctl  = wr_en && (addr == ADDR_W'(2 + 2 * k));
    assign wr_frac = wr_en && (addr == ADDR_W'(3 + 2 * k));

    pllc_chan #(
      .LOCK_CYCLES (LOCK_CYCLES),
      .DEF_MULT    (DEF_MULT),
      .FRAC_W      (FRAC_W)
    ) u_chan (
      .clk       (clk),
      .rst       (rst),
      .wr_ctl    (wr_ctl),
      .wr_frac   (wr_frac),
      .wdata     (wdata),
      .ctl_word  (ctl_flat[k*32 +: 32]),
      .frac_word (frac_flat[k*32 +: 32]),
      .eff_mult  (eff_mult_o[k*EFF_W +: EFF_W]),
      .locked    (lock_vec[k])
    );
  end

  pllc_rdmux #(
    .NUM_PLL (NUM_PLL),
    .ADDR_W  (ADDR_W)
  ) u_rdmux (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .addr      (addr),
    .ctl_flat  (ctl_flat),
    .frac_flat (frac_flat),
    .lock_vec  (lock_vec),
    .rdata     (rdata)
  );

  assign lock_o = lock_vec;

  initial begin
    a_addr_fits: assert (2 + 2 * NUM_PLL <= (1 << ADDR_W));
    a_status_fits: assert (lock_pos(NUM_PLL) < 32);
  end

endmodule

// File: tb/pllc_bank_tb.sv
module pllc_bank_tb;
  localparam int NP    = 4;
  localparam int AW    = 5;
  localparam int LC    = 6;
  localparam int DEFM  = 49;
  localparam int FW    = 24;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic            rd_en = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NP*9-1:0] eff_mult_o;
  logic [NP-1:0]   lock_o;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;

  // reference model
  logic [31:0] m_stage [NP];
  logic [31:0] m_frac  [NP];
  int          m_eff   [NP];
  int          m_acc   [NP];
  bit          m_has   [NP];

  pllc_bank #(.NUM_PLL(NP), .ADDR_W(AW), .LOCK_CYCLES(LC),
              .DEF_MULT(8'(DEFM)), .FRAC_W(FW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .eff_mult_o(eff_mult_o), .lock_o(lock_o)
  );

  always #5 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic int pos_of(input int n);
    if (n < 3) return 8 + n - 1;
    if (n == 3) return 11;
    return 9 + n;
  endfunction

  // busy state after edge j
  function automatic bit busy_at(input int p, input int j);
    return m_has[p] && (m_acc[p] <= j) && (j <= m_acc[p] + LC - 1);
  endfunction

  function automatic logic [31:0] exp_status(input int j);
    logic [31:0] s = '0;
    for (int p = 0; p < NP; p++) s[pos_of(p + 1)] = !busy_at(p, j);
    return s;
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    int w;
    @(negedge clk); #1;
    w = cyc;
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    if (a >= 2 && a < 2 + 2 * NP) begin
      int p = (a - 2) / 2;
      if (!busy_at(p, w - 1)) begin
        if (a % 2 == 0) begin
          m_stage[p] = d & 32'h0FF7_7F7F;
          if (d[31]) begin
            m_acc[p] = w; m_has[p] = 1; m_eff[p] = int'(d[27:20]) + 1;
          end
        end else begin
          m_frac[p] = d & ((32'd1 << FW) - 1);
          if (d == 0) m_stage[p] = m_stage[p] & ~32'h0006_0000;
        end
      end
    end
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input string req);
    int r;
    logic [31:0] e;
    @(negedge clk); #1;
    r = cyc;
    rd_en = 1'b1; addr = AW'(a);
    if (a == 0) e = exp_status(r - 1);
    else if (a >= 2 && a < 2 + 2 * NP) begin
      int p = (a - 2) / 2;
      if (a % 2 == 0) e = m_stage[p] | (32'(busy_at(p, r - 1)) << 31);
      else e = m_frac[p];
    end else e = 0;
    @(negedge clk); #1;
    rd_en = 1'b0;
    chk(req, rdata, e);
  endtask

  task automatic chk_ports(input string req);
    for (int p = 0; p < NP; p++) begin
      chk(req, 32'(eff_mult_o[p*9 +: 9]), 32'(m_eff[p]));
      chk(req, 32'(lock_o[p]), 32'(!busy_at(p, cyc - 1)));
    end
  endtask

  task automatic settle();
    repeat (LC + 2) @(negedge clk);
    #1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int p = 0; p < NP; p++) begin
      m_stage[p] = 32'(DEFM) << 20; m_frac[p] = 0; m_eff[p] = DEFM + 1;
      m_acc[p] = 0; m_has[p] = 0;
    end
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    chk_ports("R1 reset ports");
    for (int p = 0; p < NP; p++) begin
      rd(2 + 2 * p, "R1 reset ctl");
      rd(3 + 2 * p, "R1 reset frac");
    end
    rd(0, "R1 R6 reset status");
    chk("R6 status map", exp_status(cyc), 32'h0000_2B00);

    // R6 write to status ignored
    wr(0, 32'hFFFF_FFFF);
    rd(0, "R6 status write ignored");

    // R9 unmapped reads, hold
    rd(1, "R9 unmapped word1");
    rd(31, "R9 unmapped word31");
    @(negedge clk); #1;
    chk("R9 rdata holds", rdata, 32'd0);

    // R2 stage without commit
    wr(2, 32'h7AB5_9234);
    rd(2, "R2 staged readback");
    chk_ports("R2 no commit");

    // R3 commit at max field, R5 busy write, R7 isolation
    wr(4, 32'h8FF0_0000);
    chk("R3 eff max", 32'(eff_mult_o[9 +: 9]), 32'd256);
    wr(4, 32'h0120_0000);
    wr(5, 32'h0);
    rd(4, "R5 busy write ignored");
    chk_ports("R5 R7 during busy");
    rd(0, "R6 status while busy");
    settle();
    chk_ports("R4 after lock");
    rd(4, "R4 busy cleared");

    // R4 exact lock window on multiplier 4 (word 8)
    wr(8, 32'h8030_0000);
    for (int i = 0; i < LC; i++) begin
      chk("R4 lock low window", 32'(lock_o[3]), 32'd0);
      @(negedge clk); #1;
    end
    chk("R4 lock returns", 32'(lock_o[3]), 32'd1);
    rd(8, "R4 kick cleared with lock");
    chk("R3 eff value", 32'(eff_mult_o[27 +: 9]), 32'd4);

    // R3 boundary field 0
    wr(6, 32'h8000_0000);
    chk("R3 eff min", 32'(eff_mult_o[18 +: 9]), 32'd1);
    settle();

    // R8 zero write clears frac and dither, keeps center
    wr(6, 32'h0017_0505);
    wr(7, 32'h00AB_CDEF);
    rd(7, "R8 frac stored");
    rd(6, "R8 mode kept on nonzero");
    wr(7, 32'h0);
    rd(6, "R8 zero clears mode bits");
    chk("R8 center kept", rdata & 32'h0007_0000, 32'h0001_0000);

    // random mix
    for (int n = 0; n < 500; n++) begin
      int p = int'($urandom_range(NP - 1, 0));
      int op = int'($urandom_range(6, 0));
      logic [31:0] d = $urandom;
      case (op)
        0: wr(2 + 2 * p, d);
        1: wr(2 + 2 * p, {1'b1, d[30:0]});
        2: wr(3 + 2 * p, ($urandom_range(1, 0) != 0) ? 32'd0 : d);
        3: rd(2 + 2 * p, "R2 R3 R5 random ctl");
        4: rd(3 + 2 * p, "R8 random frac");
        5: rd(0, "R6 random status");
        default: rd(int'($urandom_range((1 << AW) - 1, 0)), "R9 random addr");
      endcase
      chk_ports("R4 R7 random ports");
    end

    summary();
  end

endmodule